// File: doc/BRIEF.md
# I2C Target Acknowledge Controller

This block is the receive-side acknowledge logic of an I2C target. It watches SCL and SDA, which arrive already synchronized to the system clock. It finds start and stop conditions and shifts in each byte most significant bit first. On the first byte after a start it compares the 7-bit address against a programmable local address and also checks for the extension-code group. It then decides whether to pull SDA low on the ninth clock.

A matching address is always acknowledged. An extension code is acknowledged only when the acknowledge-enable input is already high. Any other address is refused, and the rest of that transfer is ignored until the next start.

For data bytes, a wait-point select input places the clock-stretch either after the eighth falling edge or after the ninth falling edge. With the early wait, software can still settle the acknowledge for the byte before it pulses the release input. With the late wait, the acknowledge follows the enable level present when the byte completes. Status outputs show the address match, the extension-code hit, the received direction bit and the last accepted data byte.

Top module: `i2c_tgt_ack`

## Requirements
- R1: After reset, sda_drive_low, scl_hold_low, addr_hit, ext_hit, rw_bit and rx_data are all 0.
- R2: The first byte after a start is taken MSB first: address bits on SCL clocks 1 to 7, then the direction bit on clock 8. After the eighth falling edge, rw_bit shows that direction bit and addr_hit/ext_hit show the comparison result.
- R3: An address equal to own_addr is acknowledged (SDA held low for clock 9) whatever ack_en holds, and addr_hit goes to 1.
- R4: An address of the form 7'b11110xx sets ext_hit. If it is not the local address, it is acknowledged only if ack_en was 1 at the eighth falling edge.
- R5: Any other address is not acknowledged. No later byte of that transfer is acknowledged, stretched, or stored into rx_data until the next start.
- R6: With wait_sel=1, each acknowledged transfer stretches SCL after the ninth falling edge of every byte. A data byte is acknowledged iff ack_en was 1 at its eighth falling edge.
- R7: With wait_sel=0, each acknowledged transfer stretches SCL after the eighth falling edge of every byte. A data byte is acknowledged iff ack_en is 1 when wait_release is pulsed.
- R8: Once asserted, scl_hold_low stays high until a wait_release pulse, and drops on the clock edge that samples the pulse.
- R9: sda_drive_low and the rise of scl_hold_low change only while SCL is low; SDA stays stable for the whole high phase of the acknowledge clock.
- R10: A start, including a repeated start, restarts bit counting and makes the next byte an address byte. A stop releases SDA and SCL and returns the block to idle.
- R11: rx_data holds the most recent data byte of an acknowledged transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL line level |
| sda_i | input | 1 | Synchronized SDA line level |
| own_addr | input | ADDR_W | Local 7-bit target address |
| ack_en | input | 1 | Acknowledge enable for extension codes and data bytes |
| wait_sel | input | 1 | Wait point: 0 after eighth clock, 1 after ninth clock |
| wait_release | input | 1 | One-cycle pulse that ends the clock stretch |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge) |
| scl_hold_low | output | 1 | Pull SCL low (clock stretch) |
| addr_hit | output | 1 | Last address matched own_addr |
| ext_hit | output | 1 | Last address was an extension code |
| rw_bit | output | 1 | Direction bit of the last address byte |
| rx_data | output | BYTE_W | Last accepted data byte |

## Verification
The bench builds the block with its defaults: a 7-bit address, 8-bit bytes and two free low bits in the extension pattern. With these values it can reach the local address, several members of the 11110xx group and an unrelated address within single short transfers. These values also let one table sweep every combination of the wait point with acknowledge-enable values set before the byte and at release. Directed runs then cover a long hold waiting on the release pulse, a repeated start after a refused address, and the reset state.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } tgt_phase_e;

  // Address-byte acknowledge: own address always, extension code when enabled.
  function automatic logic addr_ack_rule(input logic hit, input logic ext, input logic en);
    return hit | (ext & en);
  endfunction

endpackage

// File: rtl/i2c_tgt_linemon.sv
module i2c_tgt_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_tgt_shifter.sv
module i2c_tgt_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  output logic [BYTE_W-1:0] shift_q,
  output logic              byte_end,
  output logic              ack_end
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_POS  = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (start_det) begin
      cnt_q <= '0;
    end else begin
      if (scl_rise && cnt_q < ACK_POS) begin
        if (cnt_q < LAST_BIT) shift_q <= {shift_q[BYTE_W-2:0], sda_i};
        cnt_q <= cnt_q + 1'b1;
      end
      if (scl_fall && cnt_q == ACK_POS) cnt_q <= '0;
    end
  end

  assign byte_end = scl_fall && (cnt_q == LAST_BIT);
  assign ack_end  = scl_fall && (cnt_q == ACK_POS);

  // R2: a completed byte is followed by its acknowledge clock, never a second byte end
  p_byte_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> !byte_end);

endmodule

// File: rtl/i2c_tgt_ackctl.sv
module i2c_tgt_ackctl
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int BYTE_W   = 8,
  parameter int EXT_FREE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_end,
  input  logic              ack_end,
  input  logic [BYTE_W-1:0] shift_q,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              wait_sel,
  input  logic              wait_release,
  output logic              sda_drv_q,
  output logic              hold_q,
  output logic              addr_hit,
  output logic              ext_hit,
  output logic              rw_bit,
  output logic [BYTE_W-1:0] rx_data
);
  localparam int PW = ADDR_W - EXT_FREE;
  localparam logic [PW-1:0] EXT_PREFIX = ~PW'(1);

  function automatic logic is_ext_code(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: PW] == EXT_PREFIX;
  endfunction

  tgt_phase_e phase_q;
  logic       pend_q;

  logic [ADDR_W-1:0] rx_addr;
  logic              rx_rw;
  logic              addr_match, addr_ext, addr_ack, release_now;

  assign rx_addr     = shift_q[BYTE_W-1 -: ADDR_W];
  assign rx_rw       = shift_q[0];
  assign addr_match  = (rx_addr == own_addr);
  assign addr_ext    = is_ext_code(rx_addr);
  assign addr_ack    = addr_ack_rule(addr_match, addr_ext, ack_en);
  assign release_now = wait_release && hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      sda_drv_q <= 1'b0;
      hold_q    <= 1'b0;
      pend_q    <= 1'b0;
      addr_hit  <= 1'b0;
      ext_hit   <= 1'b0;
      rw_bit    <= 1'b0;
      rx_data   <= '0;
    end else if (stop_det || start_det) begin
      phase_q   <= stop_det ? PH_IDLE : PH_ADDR;
      sda_drv_q <= 1'b0;
      hold_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (byte_end) begin
        case (phase_q)
          PH_ADDR: begin
            addr_hit <= addr_match;
            ext_hit  <= addr_ext;
            rw_bit   <= rx_rw;
            if (addr_ack) begin
              sda_drv_q <= 1'b1;
              hold_q    <= !wait_sel;
              phase_q   <= PH_DATA;
            end else begin
              phase_q <= PH_SKIP;
            end
          end
          PH_DATA: begin
            rx_data <= shift_q;
            if (wait_sel) begin
              sda_drv_q <= ack_en;
            end else begin
              hold_q <= 1'b1;
              pend_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (ack_end) begin
        sda_drv_q <= 1'b0;
        if (phase_q == PH_DATA && wait_sel) hold_q <= 1'b1;
      end
      if (release_now) begin
        hold_q <= 1'b0;
        if (pend_q) begin
          sda_drv_q <= ack_en;
          pend_q    <= 1'b0;
        end
      end
    end
  end

  // R3: own address acknowledged regardless of ack_en
  p_match_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end && phase_q == PH_ADDR && addr_match && !start_det && !stop_det |=> sda_drv_q);

  // R4: extension code follows the enable level seen at the eighth falling edge
  p_ext_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end && phase_q == PH_ADDR && addr_ext && !addr_match && !start_det && !stop_det
    |=> sda_drv_q == $past(ack_en));

  // R5: foreign address refused and the transfer is skipped
  p_foreign_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end && phase_q == PH_ADDR && !addr_match && !addr_ext && !start_det && !stop_det
    |=> !sda_drv_q && phase_q == PH_SKIP);

  // R5: a skipped transfer never drives SDA nor stretches SCL
  p_skip_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_SKIP |-> !sda_drv_q && !hold_q);

  // R8: the stretch persists until a release pulse
  p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && !wait_release && !start_det && !stop_det |=> hold_q);

  // R8: the release pulse ends the stretch
  p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && wait_release && !byte_end && !ack_end |=> !hold_q);

endmodule

// File: rtl/i2c_tgt_ack.sv
module i2c_tgt_ack #(
  parameter int ADDR_W   = 7,
  parameter int BYTE_W   = 8,
  parameter int EXT_FREE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              wait_sel,
  input  logic              wait_release,
  output logic              sda_drive_low,
  output logic              scl_hold_low,
  output logic              addr_hit,
  output logic              ext_hit,
  output logic              rw_bit,
  output logic [BYTE_W-1:0] rx_data
);
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              byte_end, ack_end;
  logic [BYTE_W-1:0] shift_q;

  i2c_tgt_linemon u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .shift_q   (shift_q),
    .byte_end  (byte_end),
    .ack_end   (ack_end)
  );

  i2c_tgt_ackctl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .EXT_FREE(EXT_FREE)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .byte_end     (byte_end),
    .ack_end      (ack_end),
    .shift_q      (shift_q),
    .own_addr     (own_addr),
    .ack_en       (ack_en),
    .wait_sel     (wait_sel),
    .wait_release (wait_release),
    .sda_drv_q    (sda_drive_low),
    .hold_q       (scl_hold_low),
    .addr_hit     (addr_hit),
    .ext_hit      (ext_hit),
    .rw_bit       (rw_bit),
    .rx_data      (rx_data)
  );

  // R9: the SDA pull changes only after a cycle in which SCL was low
  p_sda_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !$past(scl_i));

  // R9: a stretch begins only while SCL is low
  p_hold_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold_low) |-> !$past(scl_i));

endmodule

// File: tb/i2c_tgt_ack_test.sv
module i2c_tgt_ack_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] own_addr = 7'h3A;
  logic ack_en = 1'b0, wait_sel = 1'b0, wait_release = 1'b0;
  logic sda_drive_low, scl_hold_low, addr_hit, ext_hit, rw_bit;
  logic [7:0] rx_data;
  logic scl_i, sda_i;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sda_i = m_sda & ~sda_drive_low;
  assign scl_i = m_scl & ~scl_hold_low;

  i2c_tgt_ack uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .own_addr(own_addr), .ack_en(ack_en), .wait_sel(wait_sel),
    .wait_release(wait_release), .sda_drive_low(sda_drive_low),
    .scl_hold_low(scl_hold_low), .addr_hit(addr_hit), .ext_hit(ext_hit),
    .rw_bit(rw_bit), .rx_data(rx_data)
  );

  typedef struct packed {
    logic [6:0] own;
    logic [6:0] addr;
    logic       rw;
    logic [7:0] data;
    logic       en_pre;
    logic       en_rel;
    logic       wsel;
    logic       ack_a;
    logic       ack_d;
    logic       hit;
    logic       ext;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{7'h3A, 7'h3A, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{7'h3A, 7'h3A, 1'b1, 8'h5C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{7'h3A, 7'h3A, 1'b0, 8'h81, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{7'h3A, 7'h3A, 1'b1, 8'h7E, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{7'h3A, 7'h79, 1'b0, 8'h33, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{7'h3A, 7'h7B, 1'b1, 8'hC4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{7'h3A, 7'h15, 1'b0, 8'h99, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{7'h3A, 7'h78, 1'b1, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(4);
    m_sda = 1'b0; tick(4);
    m_scl = 1'b0; tick(3);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; tick(3);
    m_scl = 1'b1; tick(3);
    m_sda = 1'b1; tick(4);
  endtask

  task automatic clock_bit(input logic b);
    m_sda = b; tick(3);
    m_scl = 1'b1; tick(5);
    m_scl = 1'b0; tick(3);
  endtask

  task automatic pulse_release();
    wait_release = 1'b1; tick(1);
    wait_release = 1'b0; tick(2);
  endtask

  // Sends one byte plus the acknowledge clock; reports ack and where SCL was held.
  task automatic send_byte(input logic [7:0] v, input logic en_rel,
                           output logic ack, output logic h8, output logic h9);
    logic s_first;
    for (int i = 7; i >= 0; i--) clock_bit(v[i]);
    h8 = scl_hold_low;
    if (h8) begin
      ack_en = en_rel;
      tick(1);
      pulse_release();
    end
    m_sda = 1'b1; tick(3);
    m_scl = 1'b1; tick(1);
    s_first = sda_i; tick(3);
    ack = !sda_i;
    check("R9 SDA stable while SCL high on ack clock", sda_i, s_first);
    tick(1);
    m_scl = 1'b0; tick(3);
    h9 = scl_hold_low;
    if (h9) pulse_release();
  endtask

  initial begin
    logic a, h8, h9;
    logic [7:0] last_data;
    tick(3);
    // R1: reset state
    check("R1 sda_drive_low", sda_drive_low, 0);
    check("R1 scl_hold_low", scl_hold_low, 0);
    check("R1 addr_hit", addr_hit, 0);
    check("R1 ext_hit", ext_hit, 0);
    check("R1 rw_bit", rw_bit, 0);
    check("R1 rx_data", rx_data, 0);
    rst_n = 1'b1; tick(3);
    last_data = 8'h00;

    for (int k = 0; k < NV; k++) begin
      own_addr = VECS[k].own;
      wait_sel = VECS[k].wsel;
      ack_en   = VECS[k].en_pre;
      do_start();
      send_byte({VECS[k].addr, VECS[k].rw}, VECS[k].en_rel, a, h8, h9);
      check($sformatf("R3/R4/R5 address ack v%0d", k), a, VECS[k].ack_a);
      check($sformatf("R3 addr_hit v%0d", k), addr_hit, VECS[k].hit);
      check($sformatf("R4 ext_hit v%0d", k), ext_hit, VECS[k].ext);
      check($sformatf("R2 rw_bit v%0d", k), rw_bit, VECS[k].rw);
      check($sformatf("R6/R7 address hold8 v%0d", k), h8, VECS[k].ack_a & ~VECS[k].wsel);
      check($sformatf("R6/R7 address hold9 v%0d", k), h9, VECS[k].ack_a & VECS[k].wsel);
      ack_en = VECS[k].en_pre;
      send_byte(VECS[k].data, VECS[k].en_rel, a, h8, h9);
      check($sformatf("R6/R7 data ack v%0d", k), a, VECS[k].ack_a & VECS[k].ack_d);
      check($sformatf("R7 data hold8 v%0d", k), h8, VECS[k].ack_a & ~VECS[k].wsel);
      check($sformatf("R6 data hold9 v%0d", k), h9, VECS[k].ack_a & VECS[k].wsel);
      if (VECS[k].ack_a) last_data = VECS[k].data;
      check($sformatf("R11/R5 rx_data v%0d", k), rx_data, last_data);
      do_stop();
      check($sformatf("R10 stop releases SDA v%0d", k), sda_drive_low, 0);
      check($sformatf("R10 stop releases SCL v%0d", k), scl_hold_low, 0);
    end

    // R8: long hold waits for the release pulse
    own_addr = 7'h3A; wait_sel = 1'b0; ack_en = 1'b0;
    do_start();
    for (int i = 7; i >= 1; i--) clock_bit(own_addr[i-1]);
    clock_bit(1'b0);
    check("R8 hold asserted after eighth clock", scl_hold_low, 1);
    tick(25);
    check("R8 hold persists without release", scl_hold_low, 1);
    check("R8 bus SCL held low", scl_i, 0);
    wait_release = 1'b1; tick(1);
    wait_release = 1'b0;
    check("R8 hold dropped after pulse", scl_hold_low, 0);
    tick(2);
    m_sda = 1'b1; tick(3); m_scl = 1'b1; tick(3);
    check("R3 ack on held address byte", sda_i, 0);
    tick(2); m_scl = 1'b0; tick(3);
    do_stop();

    // R10: repeated start after a refused address
    wait_sel = 1'b1; ack_en = 1'b1;
    do_start();
    send_byte({7'h15, 1'b0}, 1'b1, a, h8, h9);
    check("R5 foreign address refused", a, 0);
    m_sda = 1'b1; tick(3); m_scl = 1'b1; tick(3);
    m_sda = 1'b0; tick(3); m_scl = 1'b0; tick(3);
    send_byte({7'h3A, 1'b1}, 1'b1, a, h8, h9);
    check("R10 address after repeated start acked", a, 1);
    check("R10 rw_bit after repeated start", rw_bit, 1);
    send_byte(8'h6D, 1'b1, a, h8, h9);
    check("R6 data ack after repeated start", a, 1);
    check("R11 rx_data after repeated start", rx_data, 8'h6D);
    do_stop();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule